// File: doc/BRIEF.md
# Auto-Reload Timer Bit-Rate Generator

This block produces the timing pulses for an asynchronous serial port from a single system clock. A prescaler divides the clock by a fixed count (12 by default). Each prescaler tick advances an 8-bit up-counter. When the counter steps past its all-ones value, it takes a fresh start value from the `reload_i` input and emits a one-cycle overflow pulse. A post-divider turns those overflow pulses into a 16x oversampling tick and a bit-rate tick. A doubling input halves the post-division.

The post-divider divides by 32 overall when doubling is off and by 16 when it is on. With the default prescale and an 11.0592 MHz clock, a reload of 0xFD gives 9600 bit/s exactly and 0xF4 gives 2400 bit/s. A reload of 0xF3 with a 12 MHz clock gives about 2404 bit/s, roughly 0.16 % fast.

A two-state control machine gates all counting:
- `ST_HALT` is entered from reset, and from `ST_RUN` whenever `run_i` is low at a clock edge (transition STOP).
- `ST_RUN` is entered from `ST_HALT` whenever `run_i` is high at a clock edge (transition START).
- Every other edge keeps the present state.

In `ST_HALT` the prescaler, the counter and the post-divider all hold their values.

Top module: `baud_autoreload_gen`

## Requirements
- R1: After reset the control machine is in `ST_HALT`, the counter and all dividers are zero, and every output is low. When `run_i` is then raised at a clock edge, the first `ovf_o` pulse appears exactly 256·PRESCALE+1 clock edges later.
- R2: While running, the counter steps by one every PRESCALE clock cycles. The interval between two consecutive `ovf_o` pulses is therefore (256 − reload)·PRESCALE cycles.
- R3: When the counter steps past 0xFF it loads the reload value. `ovf_o` is high for exactly one cycle, in the cycle after that step.
- R4: `reload_i` is sampled only at the wrap. A change between wraps does not shorten or lengthen the period in progress, and the new value governs the period that starts at the next wrap.
- R5: With `dbl_i` = 0, `tick16_o` pulses once for every second `ovf_o` pulse. With `dbl_i` = 1, it pulses once per `ovf_o` pulse. In both cases the tick comes one cycle after the overflow pulse that produces it.
- R6: `bit_tick_o` pulses one cycle after every sixteenth `tick16_o` pulse. The bit period is therefore 32·(256 − reload)·PRESCALE cycles with `dbl_i` = 0 and half that with `dbl_i` = 1.
- R7: While `run_i` is low the counter and all dividers hold, and no new pulses are generated. Holding `run_i` low for N cycles inside a period stretches that period by exactly N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Run enable; low freezes all counting |
| dbl_i | input | 1 | Rate doubling: 1 selects divide-by-16 after the counter, 0 selects divide-by-32 |
| reload_i | input | 8 | Counter start value, loaded at each wrap |
| ovf_o | output | 1 | One-cycle pulse per counter wrap |
| tick16_o | output | 1 | One-cycle 16x oversampling tick |
| bit_tick_o | output | 1 | One-cycle pulse per bit period |

## Verification
The assertions check the following on every cycle:
- the counter advances by exactly one per prescaler tick;
- the counter holds while halted;
- the counter holds the sampled reload value when an overflow pulse is seen;
- each 16x tick follows an overflow pulse, and with doubling on, every overflow produces one;
- each bit tick follows a 16x tick.

Only the bench scenarios can show the absolute figures:
- the period lengths across a sweep of reload values;
- that a reload change mid-period leaves the current period intact;
- the exact stretch a run-enable pause adds;
- the divide-by-two versus divide-by-one spacing of the 16x tick;
- the sixteen-tick spacing of the bit pulse.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

    // Control machine states for the bit-rate generator.
    typedef enum logic [0:0] {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    // Width of the auto-reload counter (fixed by the rate formula).
    localparam int unsigned CNT_W = 8;

endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
    parameter int unsigned PRESCALE = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);

    generate
        if (PRESCALE <= 1) begin : g_passthru
            // Divide-by-one: every enabled cycle is a tick.
            assign tick_o = en_i;
        end else begin : g_divide
            localparam int unsigned PW = $clog2(PRESCALE);
            localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

            logic [PW-1:0] div_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    div_q <= '0;
                end else if (en_i) begin
                    if (div_q == LAST) begin
                        div_q <= '0;
                    end else begin
                        div_q <= div_q + 1'b1;
                    end
                end
            end

            assign tick_o = en_i && (div_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/baud_reload_ctr.sv
module baud_reload_ctr #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic [WIDTH-1:0] reload_i,
    output logic [WIDTH-1:0] cnt_o,
    output logic             ovf_o
);

    localparam logic [WIDTH-1:0] TOP = '1;

    logic [WIDTH-1:0] cnt_q;
    logic             ovf_q;
    logic             wrap;

    // Counter is at its maximum and is about to step: it wraps.
    assign wrap = adv_i && (cnt_q == TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wrap) begin
            // The reload value is sampled here and nowhere else.
            cnt_q <= reload_i;
        end else if (adv_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= wrap;
        end
    end

    assign cnt_o = cnt_q;
    assign ovf_o = ovf_q;

endmodule

// File: rtl/baud_post_div.sv
module baud_post_div #(
    parameter int unsigned OS_RATE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic ovf_i,
    input  logic dbl_i,
    output logic tick16_o,
    output logic bit_tick_o
);

    localparam int unsigned SW = (OS_RATE > 1) ? $clog2(OS_RATE) : 1;
    localparam logic [SW-1:0] SUB_LAST = SW'(OS_RATE - 1);

    logic          half_q;
    logic          tick_q;
    logic          bit_q;
    logic [SW-1:0] sub_q;
    logic          tick_next;

    // Pass every overflow when doubling, otherwise every second one.
    assign tick_next = ovf_i && (dbl_i || half_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= 1'b0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= tick_next;
            if (ovf_i && en_i) begin
                half_q <= ~half_q;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_q <= '0;
            bit_q <= 1'b0;
        end else begin
            bit_q <= tick_q && (sub_q == SUB_LAST);
            if (tick_q) begin
                if (sub_q == SUB_LAST) begin
                    sub_q <= '0;
                end else begin
                    sub_q <= sub_q + 1'b1;
                end
            end
        end
    end

    assign tick16_o   = tick_q;
    assign bit_tick_o = bit_q;

endmodule

// File: rtl/baud_autoreload_gen.sv
module baud_autoreload_gen
    import baud_gen_pkg::*;
#(
    parameter int unsigned PRESCALE = 12,
    parameter int unsigned OS_RATE  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             dbl_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic             ovf_o,
    output logic             tick16_o,
    output logic             bit_tick_o
);

    run_state_e       state_q;
    run_state_e       state_d;
    logic             counting;
    logic             pre_tick;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_w;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (run_i)  state_d = ST_RUN;   // START
            ST_RUN:  if (!run_i) state_d = ST_HALT;  // STOP
            default: state_d = ST_HALT;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    // State outputs.
    always_comb begin
        counting = 1'b0;
        unique case (state_q)
            ST_HALT: counting = 1'b0;
            ST_RUN:  counting = 1'b1;
            default: counting = 1'b0;
        endcase
    end

    baud_prescaler #(
        .PRESCALE (PRESCALE)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (counting),
        .tick_o (pre_tick)
    );

    baud_reload_ctr #(
        .WIDTH (CNT_W)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv_i    (pre_tick),
        .reload_i (reload_i),
        .cnt_o    (cnt_q),
        .ovf_o    (ovf_w)
    );

    baud_post_div #(
        .OS_RATE (OS_RATE)
    ) u_post (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (1'b1),
        .ovf_i      (ovf_w),
        .dbl_i      (dbl_i),
        .tick16_o   (tick16_o),
        .bit_tick_o (bit_tick_o)
    );

    assign ovf_o = ovf_w;

endmodule

// File: rtl/baud_autoreload_gen_chk.sv
module baud_autoreload_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       counting,
    input logic       pre_tick,
    input logic [7:0] cnt_q,
    input logic [7:0] reload_i,
    input logic       dbl_i,
    input logic       ovf_o,
    input logic       tick16_o,
    input logic       bit_tick_o
);

    AST_WRAP_LOADS_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> cnt_q == $past(reload_i)); // R3

    AST_RELOAD_AT_WRAP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> $past(cnt_q) == 8'hFF); // R4

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_tick && cnt_q != 8'hFF) |=> cnt_q == $past(cnt_q) + 8'd1); // R2

    AST_HOLD_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        !counting |=> $stable(cnt_q)); // R7

    AST_TICK_AFTER_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        tick16_o |-> $past(ovf_o)); // R5

    AST_DBL_EVERY_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ovf_o) && $past(dbl_i)) |-> tick16_o); // R5

    AST_BIT_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick_o |-> $past(tick16_o)); // R6

endmodule

bind baud_autoreload_gen baud_autoreload_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .counting   (counting),
    .pre_tick   (pre_tick),
    .cnt_q      (cnt_q),
    .reload_i   (reload_i),
    .dbl_i      (dbl_i),
    .ovf_o      (ovf_o),
    .tick16_o   (tick16_o),
    .bit_tick_o (bit_tick_o)
);

// File: tb/tb_baud_autoreload_gen.sv
module tb_baud_autoreload_gen;

    localparam int PRE = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_i = 1'b0;
    logic       dbl_i = 1'b0;
    logic [7:0] reload_i = 8'hFD;
    logic       ovf_o, tick16_o, bit_tick_o;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz
    always @(posedge clk) cyc <= cyc + 1;

    baud_autoreload_gen #(.PRESCALE(PRE), .OS_RATE(16)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run_i),
        .dbl_i      (dbl_i),
        .reload_i   (reload_i),
        .ovf_o      (ovf_o),
        .tick16_o   (tick16_o),
        .bit_tick_o (bit_tick_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic sel(input int which);
        case (which)
            0:       return ovf_o;
            1:       return tick16_o;
            default: return bit_tick_o;
        endcase
    endfunction

    task automatic wait_evt(input int which, output int t);
        do @(negedge clk); while (!sel(which));
        t = cyc;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int ta, tb, tc, c0, quiet;

        // R1: reset state and first period from a zero count
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        quiet = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            quiet += int'(ovf_o) + int'(tick16_o) + int'(bit_tick_o);
        end
        chk("R1 outputs low after reset", quiet, 0);
        c0 = cyc;
        run_i = 1'b1;
        wait_evt(0, ta);
        chk("R1 first overflow latency", ta - c0, 256 * PRE + 1);

        // R2/R3: sweep of reload values
        for (int r = 8'hC0; r <= 8'hFF; r++) begin
            reload_i = 8'(r);
            wait_evt(0, ta);
            wait_evt(0, tb);
            chk($sformatf("R2 period reload %0h", r), tb - ta, (256 - r) * PRE);
        end

        // R3: overflow pulse width is one cycle
        reload_i = 8'hF0;
        wait_evt(0, ta);
        @(negedge clk);
        chk("R3 pulse one cycle", int'(ovf_o), 0);

        // R4: mid-period reload change does not affect the current period
        wait_evt(0, ta);
        repeat (10) @(negedge clk);
        reload_i = 8'hE0;
        wait_evt(0, tb);
        chk("R4 current period kept", tb - ta, 16 * PRE);
        wait_evt(0, tc);
        chk("R4 new period applied", tc - tb, 32 * PRE);

        // R5: 16x tick spacing with and without doubling
        reload_i = 8'hFA;
        dbl_i = 1'b0;
        wait_evt(0, ta);
        wait_evt(1, ta);
        wait_evt(1, tb);
        wait_evt(1, tc);
        chk("R5 tick16 dbl0 a", tb - ta, 2 * 6 * PRE);
        chk("R5 tick16 dbl0 b", tc - tb, 2 * 6 * PRE);
        dbl_i = 1'b1;
        wait_evt(1, ta);
        wait_evt(1, ta);
        wait_evt(1, tb);
        chk("R5 tick16 dbl1", tb - ta, 6 * PRE);
        wait_evt(0, ta);
        wait_evt(1, tb);
        chk("R5 tick16 lags ovf by one", tb - ta, 1);

        // R6: bit tick spacing, 9600-baud setting
        reload_i = 8'hFD;
        dbl_i = 1'b1;
        wait_evt(0, ta);
        wait_evt(2, ta);
        wait_evt(2, tb);
        wait_evt(2, tc);
        chk("R6 bit period dbl1", tc - tb, 16 * 3 * PRE);
        dbl_i = 1'b0;
        wait_evt(2, ta);
        wait_evt(2, tb);
        wait_evt(2, tc);
        chk("R6 bit period dbl0", tc - tb, 32 * 3 * PRE);

        // R7: run low freezes counting and stretches the period
        reload_i = 8'hF0;
        wait_evt(0, ta);
        wait_evt(0, ta);
        repeat (20) @(negedge clk);
        run_i = 1'b0;
        quiet = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            quiet += int'(ovf_o) + int'(tick16_o) + int'(bit_tick_o);
        end
        chk("R7 no pulses while halted", quiet, 0);
        run_i = 1'b1;
        wait_evt(0, tb);
        chk("R7 period stretched", tb - ta, 16 * PRE + 50);
        wait_evt(0, tc);
        chk("R7 normal after resume", tc - tb, 16 * PRE);

        finish_run();
    end

endmodule